// File: doc/BRIEF.md
# Pointer-masking control register file

This block is the register bank behind an address-masking feature in a processor core. It holds a single seven-bit control word, plus a mask and a base register for each of the three privilege levels: machine, supervisor and user. The core's CSR unit reaches the bank through a simple port. The port carries an address, read and write strobes, write data, the current privilege of the hart and a strap that says whether the feature is fitted. The bank answers with read data and an illegal-instruction flag. It raises a one-cycle pulse whenever it accepts a write, so the core can mark its extension status as dirty. All six mask and base values are driven out continuously for the masking datapath.

Only the machine level has its own control word. The supervisor and user control addresses are narrowed windows onto that word. A write through a window changes only the bits inside it. Each lower level also has a "current" bit in the word. When that bit is clear, the level may not change its own registers. Writes from that level are then dropped quietly and raise no trap.

Top module: `pmask_csr_bank`

## Requirements
- R1: Three groups of addresses are decoded, with offset 0 the control word, offset 1 the mask and offset 2 the base: machine at 0x7C0-0x7C2, supervisor at 0x9C0-0x9C2 and user at 0x8C0-0x8C2. The supervisor group exists only when HAS_S is set, and the user group only when HAS_U is set. Any other address returns zero read data, never raises illegal and changes no state.
- R2: In the control word, bits [1:0] hold the extension state. Bit 2 is user enable and bit 3 is user current. Bit 4 is supervisor enable and bit 5 is supervisor current. Bit 6 is machine enable. A machine write stores only these bits, and every higher bit reads as zero.
- R3: Reset is synchronous and active high. It clears all mask and base registers. It loads the state field with 1 (initial) when ext_present is high, and loads the whole word with 0 when ext_present is low.
- R4: The supervisor control address reads and writes the word through bits [5:0]. The user control address uses bits [3:2]. A write through either window leaves every bit outside that window unchanged.
- R5: cur_priv uses 0 for user, 1 for supervisor and 3 for machine. An access whose cur_priv is below the group's level raises csr_illegal, returns zero read data and changes nothing.
- R6: A write from supervisor (or user) to its own group is dropped unless control-word bit 5 (or bit 3) is 1. A dropped write raises no csr_illegal, does not pulse status_dirty and changes no register.
- R7: A write from a privilege above the group's level is accepted. Any machine-mode write is accepted.
- R8: Every accepted write forces the state field to 3 (dirty), whatever value is written into it. status_dirty is high for exactly the one cycle after the accepting clock edge.
- R9: With ext_present low, the control addresses read as zero without a trap, and writes to them raise csr_illegal. Any read or write of a mask or base address also raises csr_illegal.
- R10: Mask and base registers are XLEN bits wide, store every written bit, and drive m_mask, m_base, s_mask, s_base, u_mask and u_base. They change only on an accepted write to their own address.
- R11: Read data is combinational from the address. A write takes effect at the next rising edge, so a read in the following cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| cur_priv | input | 2 | Current hart privilege (0 user, 1 supervisor, 3 machine) |
| ext_present | input | 1 | Feature-fitted strap |
| csr_rdata | output | XLEN | Read data, combinational |
| csr_illegal | output | 1 | Illegal-instruction request for this access |
| status_dirty | output | 1 | One-cycle pulse after an accepted write |
| m_mask | output | XLEN | Machine mask |
| m_base | output | XLEN | Machine base |
| s_mask | output | XLEN | Supervisor mask |
| s_base | output | XLEN | Supervisor base |
| u_mask | output | XLEN | User mask |
| u_base | output | XLEN | User base |

## Verification
The assertions check on every cycle that each dirty pulse follows a write that did not trap, and that the stored state field reads dirty whenever the pulse is high. They also check that a trapped or absent write leaves every mask and base untouched, that undefined control bits read zero, and that unmapped addresses stay silent. Only the bench scenarios can show that values are correct. That covers the merge through the supervisor and user windows, the effect of each current bit on same-level writes, the reset value under both strap settings, and full-width data surviving a write-then-read. The bench shows these by comparing against its behavioural model.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
  localparam int CSR_AW = 12;
  localparam int WORD_W = 7;
  localparam int NLVL   = 3;

  typedef enum logic [1:0] {
    LVL_U   = 2'd0,
    LVL_S   = 2'd1,
    LVL_RSV = 2'd2,
    LVL_M   = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam logic [1:0] ST_OFF   = 2'd0;
  localparam logic [1:0] ST_INIT  = 2'd1;
  localparam logic [1:0] ST_CLEAN = 2'd2;
  localparam logic [1:0] ST_DIRTY = 2'd3;

  localparam int BIT_U_CUR = 3;
  localparam int BIT_S_CUR = 5;

  localparam logic [WORD_W-1:0] WIN_M = 7'h7F;
  localparam logic [WORD_W-1:0] WIN_S = 7'h3F;
  localparam logic [WORD_W-1:0] WIN_U = 7'h0C;

  typedef struct packed {
    logic hit;
    lvl_e lvl;
    sel_e sel;
    logic illegal;
    logic wr_ok;
  } acc_t;

  function automatic logic [WORD_W-1:0] win_of(lvl_e l);
    case (l)
      LVL_S:   win_of = WIN_S;
      LVL_U:   win_of = WIN_U;
      default: win_of = WIN_M;
    endcase
  endfunction

  function automatic logic [1:0] slot_of(lvl_e l);
    case (l)
      LVL_S:   slot_of = 2'd1;
      LVL_U:   slot_of = 2'd0;
      default: slot_of = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/pmask_decode.sv
module pmask_decode
  import pmask_pkg::*;
#(
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input  logic [CSR_AW-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        priv,
  input  logic              ext,
  input  logic              cur_s,
  input  logic              cur_u,
  output acc_t              acc
);
  logic       row_ok;
  lvl_e       lvl;
  logic       low_priv;
  logic       absent_bad;
  logic       same_lvl;
  logic       cur_bit;

  always_comb begin
    row_ok = 1'b0;
    lvl    = LVL_M;
    case (addr[CSR_AW-1:4])
      8'h7C: begin row_ok = 1'b1; lvl = LVL_M; end
      8'h9C: begin row_ok = HAS_S; lvl = LVL_S; end
      8'h8C: begin row_ok = HAS_U; lvl = LVL_U; end
      default: row_ok = 1'b0;
    endcase

    acc      = '0;
    acc.lvl  = lvl;
    acc.sel  = SEL_NONE;
    if (row_ok && addr[3:0] < 4'd3) begin
      acc.hit = 1'b1;
      acc.sel = sel_e'(addr[1:0]);
    end

    low_priv   = priv < lvl;
    absent_bad = !ext && (acc.sel != SEL_CTRL || wr);
    acc.illegal = acc.hit && (rd || wr) && (low_priv || absent_bad);

    same_lvl = (priv == lvl) && (lvl != LVL_M);
    cur_bit  = (lvl == LVL_S) ? cur_s : cur_u;
    acc.wr_ok = acc.hit && wr && !acc.illegal && !(same_lvl && !cur_bit);
  end
endmodule

// File: rtl/pmask_ctrl_word.sv
module pmask_ctrl_word
  import pmask_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ext,
  input  logic              upd,
  input  logic              ctrl_wr,
  input  logic [WORD_W-1:0] win,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] merged;

  always_comb begin
    merged = ctrl_wr ? ((word & ~win) | (wdata & win)) : word;
    merged[1:0] = ST_DIRTY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= ext ? {{(WORD_W-2){1'b0}}, ST_INIT} : '0;
    end else if (upd) begin
      word <= merged;
    end
  end
endmodule

// File: rtl/pmask_level_regs.sv
module pmask_level_regs #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_mask,
  input  logic            we_base,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      base <= '0;
    end else begin
      if (we_mask) mask <= wdata;
      if (we_base) base <= wdata;
    end
  end
endmodule

// File: rtl/pmask_csr_bank.sv
module pmask_csr_bank
  import pmask_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_rd,
  input  logic              csr_wr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [1:0]        cur_priv,
  input  logic              ext_present,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  output logic              status_dirty,
  output logic [XLEN-1:0]   m_mask,
  output logic [XLEN-1:0]   m_base,
  output logic [XLEN-1:0]   s_mask,
  output logic [XLEN-1:0]   s_base,
  output logic [XLEN-1:0]   u_mask,
  output logic [XLEN-1:0]   u_base
);
  localparam int PAD_W = XLEN - WORD_W;

  acc_t              acc;
  logic [WORD_W-1:0] mode_q;
  logic [1:0]        slot;
  logic [XLEN-1:0]   mask_q [NLVL];
  logic [XLEN-1:0]   base_q [NLVL];
  logic              dirty_q;

  pmask_decode #(.HAS_S(HAS_S), .HAS_U(HAS_U)) u_dec (
    .addr  (csr_addr),
    .rd    (csr_rd),
    .wr    (csr_wr),
    .priv  (cur_priv),
    .ext   (ext_present),
    .cur_s (mode_q[BIT_S_CUR]),
    .cur_u (mode_q[BIT_U_CUR]),
    .acc   (acc)
  );

  assign slot = slot_of(acc.lvl);

  pmask_ctrl_word u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ext     (ext_present),
    .upd     (acc.wr_ok),
    .ctrl_wr (acc.sel == SEL_CTRL),
    .win     (win_of(acc.lvl)),
    .wdata   (csr_wdata[WORD_W-1:0]),
    .word    (mode_q)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam bit PRESENT = (g == 2) || (g == 1 && HAS_S) || (g == 0 && HAS_U);
    if (PRESENT) begin : g_on
      pmask_level_regs #(.XLEN(XLEN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_mask (acc.wr_ok && slot == 2'(g) && acc.sel == SEL_MASK),
        .we_base (acc.wr_ok && slot == 2'(g) && acc.sel == SEL_BASE),
        .wdata   (csr_wdata),
        .mask    (mask_q[g]),
        .base    (base_q[g])
      );
    end else begin : g_off
      assign mask_q[g] = '0;
      assign base_q[g] = '0;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (acc.hit && !acc.illegal) begin
      case (acc.sel)
        SEL_CTRL: if (ext_present) csr_rdata = {{PAD_W{1'b0}}, mode_q & win_of(acc.lvl)};
        SEL_MASK: case (slot)
                    2'd0:    csr_rdata = mask_q[0];
                    2'd1:    csr_rdata = mask_q[1];
                    default: csr_rdata = mask_q[2];
                  endcase
        SEL_BASE: case (slot)
                    2'd0:    csr_rdata = base_q[0];
                    2'd1:    csr_rdata = base_q[1];
                    default: csr_rdata = base_q[2];
                  endcase
        default:  csr_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dirty_q <= 1'b0;
    else     dirty_q <= acc.wr_ok;
  end

  assign csr_illegal  = acc.illegal;
  assign status_dirty = dirty_q;
  assign u_mask = mask_q[0];
  assign u_base = base_q[0];
  assign s_mask = mask_q[1];
  assign s_base = base_q[1];
  assign m_mask = mask_q[2];
  assign m_base = base_q[2];
endmodule

// File: rtl/pmask_csr_bank_chk.sv
module pmask_csr_bank_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [11:0]     csr_addr,
  input logic            csr_rd,
  input logic            csr_wr,
  input logic            ext_present,
  input logic [XLEN-1:0] csr_rdata,
  input logic            csr_illegal,
  input logic            status_dirty,
  input logic [XLEN-1:0] m_mask,
  input logic [XLEN-1:0] m_base,
  input logic [XLEN-1:0] s_mask,
  input logic [XLEN-1:0] s_base,
  input logic [XLEN-1:0] u_mask,
  input logic [XLEN-1:0] u_base,
  input logic [6:0]      mode_word
);
  // R8: a pulse only follows a write that did not trap
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    status_dirty |-> ($past(csr_wr) && !$past(csr_illegal)));

  // R8: the stored state field is dirty while the pulse is high
  a_r8_dirty_state: assert property (@(posedge clk) disable iff (rst)
    status_dirty |-> (mode_word[1:0] == 2'd3));

  // R5 / R9: a trapped access changes no register and gives no pulse
  a_r5_trap_holds: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |=> (!status_dirty && $stable(m_mask) && $stable(m_base) &&
                     $stable(s_mask) && $stable(s_base) &&
                     $stable(u_mask) && $stable(u_base)));

  // R10: with no write strobe nothing moves
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !csr_wr |=> (!status_dirty && $stable(m_mask) && $stable(m_base) &&
                 $stable(s_mask) && $stable(s_base) &&
                 $stable(u_mask) && $stable(u_base)));

  // R2: undefined control bits read zero
  a_r2_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && csr_addr == 12'h7C0) |-> (csr_rdata[XLEN-1:7] == '0));

  // R9: mask and base trap when the feature is absent
  a_r9_absent_trap: assert property (@(posedge clk) disable iff (rst)
    (!ext_present && csr_rd && (csr_addr == 12'h7C1 || csr_addr == 12'h7C2)) |-> csr_illegal);

  // R1: an unmapped slot in a decoded row stays silent
  a_r1_unmapped: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == 12'h7C3) |-> (!csr_illegal && csr_rdata == '0));
endmodule

bind pmask_csr_bank pmask_csr_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .csr_addr     (csr_addr),
  .csr_rd       (csr_rd),
  .csr_wr       (csr_wr),
  .ext_present  (ext_present),
  .csr_rdata    (csr_rdata),
  .csr_illegal  (csr_illegal),
  .status_dirty (status_dirty),
  .m_mask       (m_mask),
  .m_base       (m_base),
  .s_mask       (s_mask),
  .s_base       (s_base),
  .u_mask       (u_mask),
  .u_base       (u_base),
  .mode_word    (mode_q)
);

// File: tb/sim_pmask_csr_bank.sv
module sim_pmask_csr_bank;
  localparam int XLEN = 64;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [11:0]     csr_addr = '0;
  logic            csr_rd = 1'b0, csr_wr = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [1:0]      cur_priv = PM;
  logic            ext_present = 1'b1;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_illegal, status_dirty;
  logic [XLEN-1:0] m_mask, m_base, s_mask, s_base, u_mask, u_base;

  int n_run = 0, n_fail = 0;
  bit cmp_on = 0;

  // behavioural model: index 0 user, 1 supervisor, 2 machine
  logic [6:0]      md_word;
  logic [XLEN-1:0] md_mask [3];
  logic [XLEN-1:0] md_base [3];
  bit              md_dirty;

  always #2 clk = ~clk;

  pmask_csr_bank #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .cur_priv(cur_priv), .ext_present(ext_present),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .status_dirty(status_dirty),
    .m_mask(m_mask), .m_base(m_base), .s_mask(s_mask), .s_base(s_base),
    .u_mask(u_mask), .u_base(u_base)
  );

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R10 m_mask", m_mask, md_mask[2]);
      check("R10 m_base", m_base, md_base[2]);
      check("R10 s_mask", s_mask, md_mask[1]);
      check("R10 s_base", s_base, md_base[1]);
      check("R10 u_mask", u_mask, md_mask[0]);
      check("R10 u_base", u_base, md_base[0]);
      check("R8 status_dirty", XLEN'(status_dirty), XLEN'(md_dirty));
    end
  end

  task automatic do_reset(bit strap);
    cmp_on = 0;
    rst = 1'b1; ext_present = strap; csr_rd = 0; csr_wr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    md_word = strap ? 7'h01 : 7'h00;
    for (int i = 0; i < 3; i++) begin md_mask[i] = '0; md_base[i] = '0; end
    md_dirty = 0;
    cmp_on = 1;
  endtask

  task automatic acc(string tag, logic [11:0] a, bit r, bit w, logic [XLEN-1:0] d, logic [1:0] p);
    int lv, sl, ix;
    bit hit, ill, gated, ok, curb;
    logic [6:0] win, nw;
    logic [XLEN-1:0] exp_rd;
    @(negedge clk);
    csr_addr = a; csr_rd = r; csr_wr = w; csr_wdata = d; cur_priv = p;
    #1;
    case (a[11:4])
      8'h7C: lv = 3;
      8'h9C: lv = 1;
      8'h8C: lv = 0;
      default: lv = -1;
    endcase
    sl  = int'(a[3:0]);
    hit = (lv >= 0) && (sl < 3);
    ix  = (lv == 3) ? 2 : ((lv < 0) ? 0 : lv);
    ill = hit && (r || w) && ((int'(p) < lv) || (!ext_present && (sl != 0 || w)));
    win = (lv == 3) ? 7'h7F : ((lv == 1) ? 7'h3F : 7'h0C);
    curb  = (lv == 1) ? md_word[5] : md_word[3];
    gated = (int'(p) == lv) && (lv != 3) && !curb;
    ok    = hit && w && !ill && !gated;
    if (!hit || ill)  exp_rd = '0;
    else if (sl == 0) exp_rd = ext_present ? XLEN'(md_word & win) : '0;
    else if (sl == 1) exp_rd = md_mask[ix];
    else              exp_rd = md_base[ix];
    if (r || w) check({tag, " illegal"}, XLEN'(csr_illegal), XLEN'(ill));
    if (r)      check({tag, " rdata"}, csr_rdata, exp_rd);
    nw = md_word;
    if (ok) begin
      if (sl == 0) nw = (md_word & ~win) | (d[6:0] & win);
      nw[1:0] = 2'd3;
    end
    @(posedge clk);
    #1;
    md_word  = nw;
    if (ok && sl == 1) md_mask[ix] = d;
    if (ok && sl == 2) md_base[ix] = d;
    md_dirty = ok;
  endtask

  task automatic idle();
    acc("idle", 12'h000, 0, 0, '0, PM);
  endtask

  bit done = 0;

  initial begin
    do_reset(1'b1);
    acc("R3", 12'h7C0, 1, 0, '0, PM);
    acc("R3", 12'h7C1, 1, 0, '0, PM);
    acc("R3", 12'h9C2, 1, 0, '0, PM);
    acc("R3", 12'h8C1, 1, 0, '0, PM);
    acc("R2", 12'h7C0, 0, 1, '1, PM);
    acc("R2", 12'h7C0, 1, 0, '0, PM);
    check("R2 literal", csr_rdata, 64'h7F);
    acc("R8", 12'h7C0, 0, 1, '0, PM);
    acc("R8", 12'h7C0, 1, 0, '0, PM);
    acc("R11", 12'h7C1, 0, 1, 64'hDEAD_BEEF_0123_4567, PM);
    acc("R11", 12'h7C1, 1, 0, '0, PM);
    check("R11 literal", csr_rdata, 64'hDEAD_BEEF_0123_4567);
    acc("R2", 12'h7C0, 0, 1, 64'h7C, PM);
    acc("R4", 12'h9C0, 1, 0, '0, PS);
    acc("R4", 12'h8C0, 1, 0, '0, PU);
    acc("R4", 12'h9C0, 0, 1, '0, PS);
    acc("R4", 12'h7C0, 1, 0, '0, PM);
    check("R4 literal", csr_rdata, 64'h43);
    acc("R6", 12'h9C1, 0, 1, 64'hAAAA_5555_AAAA_5555, PS);
    acc("R6", 12'h9C1, 1, 0, '0, PS);
    acc("R7", 12'h9C1, 0, 1, 64'h1234_5678_9ABC_DEF0, PM);
    acc("R7", 12'h9C1, 1, 0, '0, PS);
    acc("R5", 12'h9C1, 0, 1, 64'hFFFF, PU);
    acc("R5", 12'h7C0, 1, 0, '0, PU);
    acc("R5", 12'h7C2, 0, 1, 64'h77, PS);
    acc("R6", 12'h8C1, 0, 1, 64'h0F0F, PU);
    acc("R6", 12'h8C1, 1, 0, '0, PU);
    acc("R7", 12'h8C1, 0, 1, 64'hF0F0_0000_0000_F0F0, PS);
    acc("R4", 12'h8C0, 0, 1, 64'hFFFF_FFFF_FFFF_FFF8, PM);
    acc("R4", 12'h7C0, 1, 0, '0, PM);
    check("R4 window", csr_rdata, 64'h4B);
    acc("R7", 12'h8C2, 0, 1, 64'h8000_0000_0000_0001, PU);
    acc("R7", 12'h8C2, 1, 0, '0, PU);
    acc("R6", 12'h9C2, 0, 1, 64'h55, PS);
    acc("R7", 12'h7C0, 0, 1, 64'h20, PM);
    acc("R7", 12'h9C2, 0, 1, 64'h55, PS);
    acc("R7", 12'h9C2, 1, 0, '0, PS);
    acc("R8", 12'h7C0, 0, 1, 64'h01, PM);
    acc("R8", 12'h7C0, 1, 0, '0, PM);
    acc("R10", 12'h7C2, 0, 1, 64'hCAFE_F00D_0000_FFFF, PM);
    acc("R10", 12'h7C2, 1, 0, '0, PM);
    acc("R1", 12'h7C3, 1, 1, 64'h99, PM);
    acc("R1", 12'h8C7, 1, 0, '0, PM);
    acc("R1", 12'h123, 1, 1, 64'h5, PU);
    idle();
    idle();
    do_reset(1'b0);
    acc("R3", 12'h7C0, 1, 0, '0, PM);
    acc("R9", 12'h7C0, 0, 1, 64'h7F, PM);
    acc("R9", 12'h7C1, 1, 0, '0, PM);
    acc("R9", 12'h9C2, 0, 1, 64'h3, PM);
    acc("R9", 12'h8C0, 1, 0, '0, PU);
    acc("R9", 12'h8C2, 1, 0, '0, PM);
    idle();
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule